// File: doc/BRIEF.md
# Bit-Serial Lightweight Feistel Encryption Core

This block encrypts one 2N-bit block under a 4N-bit key with a small Feistel cipher, and it handles one bit per clock. Plaintext and key enter serially while the block is idle. A start pulse then runs all rounds, each taking N cycles, and the ciphertext leaves on a single output pin. The core is meant for area-starved designs where several hundred cycles per block are acceptable.

The left half x, the right half y and the four key words sit in right-shifting registers. Each round XORs the right half with the AND of x and x rotated left by 5, with x rotated left by 1, and with the round key. The round key is the oldest key word. The key words advance through a generator that reuses the same nonlinear function and adds a constant. Rotated operand bits come from two fixed taps. While the bit index is still inside the rotation distance, the tap is taken from the register that holds the unconsumed bits of the word; after that it is taken from the register that is collecting the consumed bits. Only distances 1 and 5 need such a selector.

Top module: `serial_feistel_core`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `done` and `dout` are both 0.
- R2: In the idle state, each cycle with `load_mode` high shifts `key_in` into a 4N-bit key chain and `din` into a 2N-bit data chain, least significant bit first. Only the last 4N key bits and the last 2N data bits are kept. The key is {w3,w2,w1,w0}, and w0 is the first round key. The block is {x,y}, with x the left half.
- R3: Each round computes x' = y ^ (x & rotl(x,5)) ^ rotl(x,1) ^ k and y' = x, where k is the current w0. With the default N=16 and 32 rounds, key 0x1918111009080100 and block 0x65656877 give 0x770d2c76.
- R4: After every round the key words move one place (w0←w1, w1←w2, w2←w3). The new w3 is w0 ^ (w1 & rotl(w1,5)) ^ rotl(w1,1) ^ c. The constant c is 2^N−4 with bit 0 replaced by z_i. For N of 16 or 24, z comes from z_{i+5}=z_{i+2}^z_i, seeded with five ones and restarted on every start.
- R5: `done` first reads 1 after exactly ROUNDS×N rising edges following the edge that samples `start`.
- R6: `done` stays high for exactly 2N cycles. During those cycles `dout` gives the ciphertext {x,y}, least significant bit first, one bit per cycle.
- R7: `dout` is 0 whenever `done` is 0.
- R8: A `start` pulse while rounds are running or ciphertext is being shifted out is ignored. It changes neither the result nor its timing.
- R9: `load_mode`, `din` and `key_in` are ignored while the core is not idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_mode | input | 1 | Serial load enable, honoured only when idle |
| din | input | 1 | Serial plaintext bit |
| key_in | input | 1 | Serial key bit |
| start | input | 1 | Begins encryption of the loaded block, honoured only when idle |
| dout | output | 1 | Serial ciphertext bit, valid while done is high |
| done | output | 1 | High during the 2N ciphertext output cycles |

## Verification
The run-length, output-width and bit-index properties assume that every start leads to a full set of rounds and a full output phase. Reset is therefore applied only once, before any traffic. The bench waits for `done` to fall before it loads or starts the next block. The only stray control it drives is inside a running encryption: an extra `start` pulse and a burst of `load_mode` with toggling data. Expected ciphertext comes from a word-level model of the round and key generator, and that model is itself checked against one fixed known vector.

// File: rtl/serial_feistel_core.sv
`timescale 1ns/1ps
module serial_feistel_core #(
  parameter int N      = 16,
  parameter int ROUNDS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_mode,
  input  logic din,
  input  logic key_in,
  input  logic start,
  output logic dout,
  output logic done
);
  localparam int BW = $clog2(N);
  localparam int RW = $clog2(ROUNDS);
  localparam int OW = $clog2(2 * N);
  localparam int LW = (N == 32) ? 6 : 5;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_OUT} state_t;

  state_t st;
  logic [N-1:0] a, b, k, t0, t1, t2;
  logic [BW-1:0] bi;
  logic [RW-1:0] rnd;
  logic [OW-1:0] oc;
  logic [LW-1:0] lf, lf_nx;

  generate
    if (N == 32) begin : g_lfsr6
      assign lf_nx = {lf[0] ^ lf[1], lf[LW-1:1]};
    end else begin : g_lfsr5
      assign lf_nx = {lf[0] ^ lf[2], lf[LW-1:1]};
    end
  endgenerate

  wire run      = (st == S_RUN);
  wire last_bit = (bi == BW'(N - 1));
  wire near1    = (bi == '0);
  wire near5    = (bi < BW'(5));

  wire x_r1  = near1 ? a[N-1]  : b[N-1];
  wire x_r5  = near5 ? a[N-5]  : b[N-5];
  wire k_r1  = near1 ? t0[N-1] : k[N-1];
  wire k_r5  = near5 ? t0[N-5] : k[N-5];
  wire cbit  = near1 ? lf[0] : (bi >= BW'(2));

  wire x_new = b[0] ^ (a[0] & x_r5) ^ x_r1 ^ k[0];
  wire t_new = k[0] ^ (t0[0] & k_r5) ^ k_r1 ^ cbit;

  assign done = (st == S_OUT);
  assign dout = done & b[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      bi  <= '0;
      rnd <= '0;
      oc  <= '0;
      lf  <= '1;
      a   <= '0;
      b   <= '0;
      k   <= '0;
      t0  <= '0;
      t1  <= '0;
      t2  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (load_mode) begin
            a  <= {din, a[N-1:1]};
            b  <= {a[0], b[N-1:1]};
            t2 <= {key_in, t2[N-1:1]};
            t1 <= {t2[0], t1[N-1:1]};
            t0 <= {t1[0], t0[N-1:1]};
            k  <= {t0[0], k[N-1:1]};
          end else if (start) begin
            st  <= S_RUN;
            bi  <= '0;
            rnd <= '0;
            lf  <= '1;
          end
        end
        S_RUN: begin
          a  <= {x_new, a[N-1:1]};
          b  <= {a[0], b[N-1:1]};
          t2 <= {t_new, t2[N-1:1]};
          t1 <= {t2[0], t1[N-1:1]};
          t0 <= {t1[0], t0[N-1:1]};
          k  <= {t0[0], k[N-1:1]};
          bi <= last_bit ? '0 : bi + 1'b1;
          if (last_bit) begin
            lf  <= lf_nx;
            rnd <= rnd + 1'b1;
            if (rnd == RW'(ROUNDS - 1)) begin
              st <= S_OUT;
              oc <= '0;
            end
          end
        end
        S_OUT: begin
          a  <= {1'b0, a[N-1:1]};
          b  <= {a[0], b[N-1:1]};
          oc <= oc + 1'b1;
          if (oc == OW'(2 * N - 1)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_feistel_core_chk.sv
`timescale 1ns/1ps
module serial_feistel_core_chk #(
  parameter int N      = 16,
  parameter int ROUNDS = 32,
  localparam int BW = $clog2(N),
  localparam int LW = (N == 32) ? 6 : 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          running,
  input logic [BW-1:0] bit_idx,
  input logic [LW-1:0] lfsr
);
  localparam int CW = $clog2(ROUNDS * N + 1);
  localparam int DW = $clog2(2 * N + 1);

  logic [CW-1:0] rcnt;
  logic [DW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= '0;
      dcnt <= '0;
    end else begin
      rcnt <= running ? rcnt + 1'b1 : '0;
      dcnt <= done ? dcnt + 1'b1 : '0;
    end
  end

  a_r5_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> rcnt == CW'(ROUNDS * N));

  a_r6_done_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> dcnt == DW'(2 * N));

  a_r6_done_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> dcnt < DW'(2 * N));

  a_r8_bit_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (running && bit_idx != BW'(N - 1)) |=> bit_idx == $past(bit_idx) + BW'(1));

  a_r4_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> lfsr != '0);
endmodule

bind serial_feistel_core serial_feistel_core_chk #(.N(N), .ROUNDS(ROUNDS)) chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .running(run), .bit_idx(bi), .lfsr(lf)
);

// File: tb/serial_feistel_core_tb_top.sv
`timescale 1ns/1ps
module serial_feistel_core_tb_top;
  localparam int N = 16;
  localparam int ROUNDS = 32;
  localparam int LAT = ROUNDS * N + 1;

  logic clk = 0;
  logic rst_n = 0;
  logic load_mode = 0, din = 0, key_in = 0, start = 0;
  logic dout, done;
  int checks = 0, errors = 0, cyc = 0;
  logic exp_q[$];

  always #2.5 clk = ~clk;

  serial_feistel_core #(.N(N), .ROUNDS(ROUNDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .din(din),
    .key_in(key_in), .start(start), .dout(dout), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rol1(input logic [15:0] v);
    return {v[14:0], v[15]};
  endfunction
  function automatic logic [15:0] rol5(input logic [15:0] v);
    return {v[10:0], v[15:11]};
  endfunction

  function automatic logic [31:0] ref_enc(input logic [63:0] key, input logic [31:0] pt);
    logic [15:0] x, y, kk, w1, w2, w3, tmp, c;
    logic [4:0] l;
    {w3, w2, w1, kk} = key;
    {x, y} = pt;
    l = 5'h1f;
    for (int r = 0; r < ROUNDS; r++) begin
      tmp = x;
      x = y ^ (x & rol5(x)) ^ rol1(x) ^ kk;
      y = tmp;
      c = 16'hfffc | {15'b0, l[0]};
      tmp = kk ^ (w1 & rol5(w1)) ^ rol1(w1) ^ c;
      kk = w1; w1 = w2; w2 = w3; w3 = tmp;
      l = {l[0] ^ l[2], l[4:1]};
    end
    return {x, y};
  endfunction

  // scoreboard monitor: R3 R4 R6
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected output bit", {63'b0, dout}, 64'h0);
      else begin
        logic e;
        e = exp_q.pop_front();
        chk(dout === e, "R3/R4/R6 ciphertext bit", {63'b0, dout}, {63'b0, e});
      end
    end
  end

  task automatic load(input logic [63:0] key, input logic [31:0] pt);
    load_mode = 1;
    for (int i = 0; i < 64; i++) begin
      key_in = key[i];
      din = (i >= 32) ? pt[i-32] : ~pt[i];
      @(negedge clk);
    end
    load_mode = 0;
  endtask

  task automatic run_enc(input logic [31:0] exp_ct, input bit disturb);
    int c;
    bit quiet;
    for (int i = 0; i < 32; i++) exp_q.push_back(exp_ct[i]);
    start = 1;
    @(negedge clk);
    start = 0;
    c = 1;
    quiet = 1;
    while (!done && c < 2000) begin
      if (dout !== 1'b0) quiet = 0;
      if (disturb) begin
        start = (c == 100) || (c == 513);
        if (c >= 200 && c < 230) begin
          load_mode = 1; din = c[0]; key_in = ~c[1];
        end else load_mode = 0;
      end
      @(negedge clk);
      c++;
    end
    chk(c == LAT, "R5 latency to done", c, LAT);
    chk(quiet, "R7 dout low while done low", {63'b0, !quiet}, 64'h0);
    while (done) begin
      start = disturb;
      load_mode = disturb;
      @(negedge clk);
    end
    start = 0;
    load_mode = 0;
    chk(exp_q.size() == 0, "R6 exactly 2N output bits", exp_q.size(), 0);
    exp_q.delete();
    repeat (3) begin
      din = 1; @(negedge clk);
      chk(dout === 1'b0 && done === 1'b0, "R7 idle outputs low", {62'b0, done, dout}, 64'h0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] kv;
    logic [31:0] pv;
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && dout === 1'b0, "R1 outputs in reset", {62'b0, done, dout}, 64'h0);
    rst_n = 1;
    @(negedge clk);
    chk(done === 1'b0 && dout === 1'b0, "R1 outputs after reset", {62'b0, done, dout}, 64'h0);

    // R3 model self-check against the fixed vector
    chk(ref_enc(64'h1918111009080100, 32'h65656877) == 32'h770d2c76, "R3 reference model vector",
        ref_enc(64'h1918111009080100, 32'h65656877), 32'h770d2c76);

    // R2 R3: fixed vector, first 2N data bits are junk
    load(64'h1918111009080100, 32'h65656877);
    run_enc(32'h770d2c76, 1'b0);

    load(64'h0, 32'h0);
    run_enc(ref_enc(64'h0, 32'h0), 1'b0);

    load('1, '1);
    run_enc(ref_enc('1, '1), 1'b0);

    // R8 R9: stray start and load during run and output
    kv = 64'h0123456789abcdef; pv = 32'hdeadbeef;
    load(kv, pv);
    run_enc(ref_enc(kv, pv), 1'b1);

    kv = 64'hf0e1d2c3b4a59687; pv = 32'h13579bdf;
    load(kv, pv);
    run_enc(ref_enc(kv, pv), 1'b1);

    kv = 64'h8000000000000001; pv = 32'h00010000;
    load(kv, pv);
    run_enc(ref_enc(kv, pv), 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule